// File: doc/BRIEF.md
# Machine Trap Entry and Return Unit

This block controls the change of privilege for a small 32-bit core that runs in a user mode and a machine mode. When decode or execute reports a trapping instruction, the block takes the trap. A system call uses cause 8, and an instruction the core cannot execute (for example a multiply with no hardware behind it) uses cause 2. On a trap the block captures the instruction's PC and the cause code, pushes the privilege/interrupt-enable context, and requests a redirect to a fixed handler entry. Traps taken from user mode enter at 0x100. Traps taken while already in machine mode enter at a separate entry. An environment return (ERET) issued in machine mode redirects fetch to the saved exception PC and pops the context stack. Handler software decides whether execution resumes at the trapping instruction or after it by rewriting the saved PC before ERET.

A small register-access port gives handler software read, write and atomic swap access to the exception PC, the cause register and the scratch register. The same port gives read-only access to the status stack.

The controller is a two-state machine over the current privilege, USER and MACHINE. Its transitions are:
- TRAP_ENTER: USER to MACHINE on a trap request or on an ERET issued from user mode.
- TRAP_NEST: MACHINE to MACHINE on a trap request.
- RET_POP: MACHINE to the popped mode on an ERET.
- HOLD: no change in either state when nothing fires.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the unit is in the following state. The mode is user (priv_mode = 0). redirect_valid is 0. The exception PC, cause and scratch registers read 0. The status word reads 0x55, meaning every level holds user mode with interrupts enabled.
- R2: A trap request taken in user mode has the following effects one cycle later. redirect_valid is 1 and redirect_pc is 0x100. The exception PC holds trap_pc, the cause register holds trap_cause, and the mode is machine. Callers use cause 8 for a system call and cause 2 for an illegal or unsupported instruction.
- R3: A trap request taken in machine mode redirects to MACH_VEC, which defaults to 0x1C0. It captures the PC and the cause in the same way as a trap from user mode.
- R4: The status word packs context level k into bits [2k+1:2k], with the mode at bit 2k+1 (1 = machine) and the interrupt enable at bit 2k. Level 0 is the current context. A trap shifts every level up by one and sets level 0 to machine mode with interrupts disabled.
- R5: An ERET in machine mode does three things. It redirects to the value the exception PC held in that cycle. It restores level 0 from level 1 and shifts the higher levels down. It refills the top level with user mode and interrupts enabled.
- R6: An ERET in user mode is treated as an illegal instruction. It records cause 2, captures trap_pc, enters machine mode and redirects to 0x100.
- R7: When a trap request and an ERET arrive in the same cycle, the trap is taken, with the cause from trap_cause, and the ERET is dropped.
- R8: The CSR port works as follows. csr_sel selects the register: 0 for the exception PC, 1 for the cause, 2 for scratch, 3 for status. csr_op selects the operation: 0 none, 1 read, 2 write, 3 swap. csr_rdata shows the selected register's current value combinationally for read and swap, and shows 0 for none and write. Write and swap store csr_wdata at the clock edge.
- R9: A swap on the scratch register returns its old value on csr_rdata and holds the new value from the next cycle onward.
- R10: When software writes the exception PC several times before an ERET, the ERET uses the value of the most recent write.
- R11: Writes to the status selector have no effect.
- R12: In a cycle where a trap is taken, the trap's PC and cause replace any CSR-port write to the exception PC or cause register in that same cycle.
- R13: redirect_valid is 0 in the cycle after any cycle in which neither a trap nor an ERET is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request strobe from execute |
| trap_cause | input | CAUSE_W | Cause code of the requesting trap |
| trap_pc | input | XLEN | PC of the instruction in execute |
| eret_req | input | 1 | Environment-return strobe |
| csr_op | input | 2 | CSR operation: none, read, write, swap |
| csr_sel | input | 2 | CSR selector |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| redirect_valid | output | 1 | Fetch redirect request, registered |
| redirect_pc | output | XLEN | Fetch redirect target |
| priv_mode | output | 1 | Current mode, 1 = machine |

## Verification
The bench goes after six corner cases, each paired with a mutant it should catch:
- A trap and an ERET colliding in one cycle. A design that let the ERET win would pop the stack and jump to the saved PC instead of the handler.
- An ERET from user mode. A unit that simply ignored it, or returned, would leave the cause at its old value and miss the handler redirect.
- Nested traps followed by a chain of returns. A wrong shift direction or a wrong refill value shows up in the status word and in the mode after each pop.
- Repeated writes to the exception PC before a return. A design with a stale target would return to the wrong PC.
- A swap that reads back the new value instead of the old one.
- A software write that overrides a trap in the same cycle.

The bench also runs a pseudo-random stream against an arithmetic reference model of the mode, the stack and the registers.

// File: rtl/mtrap_pkg.sv
`timescale 1ns/1ps
package mtrap_pkg;

    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_MACH = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        CSR_NOP   = 2'd0,
        CSR_READ  = 2'd1,
        CSR_WRITE = 2'd2,
        CSR_SWAP  = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        SEL_EPC     = 2'd0,
        SEL_CAUSE   = 2'd1,
        SEL_SCRATCH = 2'd2,
        SEL_STATUS  = 2'd3
    } csr_sel_e;

    // one context level: privilege above interrupt enable
    typedef struct packed {
        mode_e prv;
        logic  ie;
    } lvl_t;

    localparam lvl_t LVL_IDLE      = '{prv: MODE_USER, ie: 1'b1};
    localparam int   CAUSE_ILLEGAL = 2;
    localparam int   CAUSE_SYSCALL = 8;

endpackage

// File: rtl/mtrap_ctrl.sv
`timescale 1ns/1ps
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              CAUSE_W      = 4,
    parameter int              STACK_LEVELS = 3,
    parameter logic [XLEN-1:0] USER_VEC     = 'h100,
    parameter logic [XLEN-1:0] MACH_VEC     = 'h1C0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               eret_req,
    output logic               trap_fire,
    output logic               ret_fire,
    output logic [CAUSE_W-1:0] cause_eff,
    output logic [XLEN-1:0]    vec_pc,
    output logic [XLEN-1:0]    status_word,
    output mode_e              mode
);

    localparam int STW = 2 * (STACK_LEVELS + 1);

    mode_e mode_q, mode_d;
    logic  ie_q, ie_d;
    lvl_t  prev_q [STACK_LEVELS];
    lvl_t  prev_d [STACK_LEVELS];
    logic [STW-1:0] st_packed;

    // Event decode: a trap always beats a return.
    always_comb begin
        trap_fire = trap_req | (eret_req & (mode_q == MODE_USER));
        ret_fire  = eret_req & ~trap_req & (mode_q == MODE_MACH);
        cause_eff = trap_req ? trap_cause : CAUSE_W'(CAUSE_ILLEGAL);
        vec_pc    = (mode_q == MODE_USER) ? USER_VEC : MACH_VEC;
    end

    // Next-state process
    always_comb begin
        mode_d = mode_q;
        ie_d   = ie_q;
        prev_d = prev_q;
        unique case (mode_q)
            MODE_USER: begin
                if (trap_fire) begin                 // TRAP_ENTER
                    mode_d    = MODE_MACH;
                    ie_d      = 1'b0;
                    prev_d[0] = '{prv: mode_q, ie: ie_q};
                    for (int i = 1; i < STACK_LEVELS; i++) prev_d[i] = prev_q[i-1];
                end
            end
            MODE_MACH: begin
                if (trap_fire) begin                 // TRAP_NEST
                    ie_d      = 1'b0;
                    prev_d[0] = '{prv: mode_q, ie: ie_q};
                    for (int i = 1; i < STACK_LEVELS; i++) prev_d[i] = prev_q[i-1];
                end else if (ret_fire) begin         // RET_POP
                    mode_d = prev_q[0].prv;
                    ie_d   = prev_q[0].ie;
                    for (int i = 0; i < STACK_LEVELS - 1; i++) prev_d[i] = prev_q[i+1];
                    prev_d[STACK_LEVELS-1] = LVL_IDLE;
                end
            end
            default: mode_d = MODE_USER;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_USER;
            ie_q   <= 1'b1;
            for (int i = 0; i < STACK_LEVELS; i++) prev_q[i] <= LVL_IDLE;
        end else begin
            mode_q <= mode_d;
            ie_q   <= ie_d;
            prev_q <= prev_d;
        end
    end

    assign st_packed[1:0] = {mode_q, ie_q};
    for (genvar k = 0; k < STACK_LEVELS; k++) begin : g_pack
        assign st_packed[2*k+3:2*k+2] = prev_q[k];
    end
    assign status_word = XLEN'(st_packed);
    assign mode        = mode_q;

    mode_e top_prv;
    assign top_prv = prev_q[0].prv;

    // R2
    trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (mode_q == MODE_MACH) && !ie_q);

    // R6
    eret_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !trap_req && mode_q == MODE_USER) |=>
            (mode_q == MODE_MACH) && (prev_q[0].prv == MODE_USER));

    // R5
    ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> mode_q == $past(top_prv));

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_fire && !ret_fire) |=> $stable(status_word));

endmodule

// File: rtl/mtrap_csr.sv
`timescale 1ns/1ps
module mtrap_csr
    import mtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_fire,
    input  logic [CAUSE_W-1:0] cause_eff,
    input  logic [XLEN-1:0]    pc_in,
    input  csr_op_e            op,
    input  csr_sel_e           sel,
    input  logic [XLEN-1:0]    wdata,
    input  logic [XLEN-1:0]    status_word,
    output logic [XLEN-1:0]    rdata,
    output logic [XLEN-1:0]    epc
);

    logic [XLEN-1:0]    epc_q, scratch_q, sel_val;
    logic [CAUSE_W-1:0] cause_q;
    logic               wr_en, rd_en;

    assign wr_en = (op == CSR_WRITE) || (op == CSR_SWAP);
    assign rd_en = (op == CSR_READ)  || (op == CSR_SWAP);

    always_comb begin
        unique case (sel)
            SEL_EPC:     sel_val = epc_q;
            SEL_CAUSE:   sel_val = XLEN'(cause_q);
            SEL_SCRATCH: sel_val = scratch_q;
            SEL_STATUS:  sel_val = status_word;
            default:     sel_val = '0;
        endcase
        rdata = rd_en ? sel_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q     <= '0;
            cause_q   <= '0;
            scratch_q <= '0;
        end else begin
            if (trap_fire) begin
                epc_q   <= pc_in;
                cause_q <= cause_eff;
            end else if (wr_en && sel == SEL_EPC) begin
                epc_q <= wdata;
            end else if (wr_en && sel == SEL_CAUSE) begin
                cause_q <= wdata[CAUSE_W-1:0];
            end
            if (wr_en && sel == SEL_SCRATCH) scratch_q <= wdata;
        end
    end

    assign epc = epc_q;

    // R2
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> epc_q == $past(pc_in));

    // R12
    cause_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> cause_q == $past(cause_eff));

    // R9
    scratch_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CSR_SWAP && sel == SEL_SCRATCH) |=> scratch_q == $past(wdata));

endmodule

// File: rtl/mtrap_redirect.sv
`timescale 1ns/1ps
module mtrap_redirect #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_fire,
    input  logic            ret_fire,
    input  logic [XLEN-1:0] vec_pc,
    input  logic [XLEN-1:0] epc_in,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= trap_fire | ret_fire;
            if (trap_fire)     redirect_pc <= vec_pc;
            else if (ret_fire) redirect_pc <= epc_in;
        end
    end

    // R5
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> redirect_valid && (redirect_pc == $past(epc_in)));

    // R13
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_fire && !ret_fire) |=> !redirect_valid);

endmodule

// File: rtl/mtrap_unit.sv
`timescale 1ns/1ps
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              CAUSE_W      = 4,
    parameter int              STACK_LEVELS = 3,
    parameter logic [XLEN-1:0] USER_VEC     = 'h100,
    parameter logic [XLEN-1:0] MACH_VEC     = 'h1C0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic               eret_req,
    input  logic [1:0]         csr_op,
    input  logic [1:0]         csr_sel,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               priv_mode
);

    logic               trap_fire, ret_fire;
    logic [CAUSE_W-1:0] cause_eff;
    logic [XLEN-1:0]    vec_pc, status_word, epc;
    mode_e              mode;

    mtrap_ctrl #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .STACK_LEVELS(STACK_LEVELS),
        .USER_VEC(USER_VEC), .MACH_VEC(MACH_VEC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
        .eret_req(eret_req), .trap_fire(trap_fire), .ret_fire(ret_fire),
        .cause_eff(cause_eff), .vec_pc(vec_pc), .status_word(status_word), .mode(mode)
    );

    mtrap_csr #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .trap_fire(trap_fire), .cause_eff(cause_eff),
        .pc_in(trap_pc), .op(csr_op_e'(csr_op)), .sel(csr_sel_e'(csr_sel)),
        .wdata(csr_wdata), .status_word(status_word), .rdata(csr_rdata), .epc(epc)
    );

    mtrap_redirect #(.XLEN(XLEN)) u_redirect (
        .clk(clk), .rst_n(rst_n), .trap_fire(trap_fire), .ret_fire(ret_fire),
        .vec_pc(vec_pc), .epc_in(epc), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    assign priv_mode = (mode == MODE_MACH);

endmodule

// File: tb/mtrap_unit_tb.sv
`timescale 1ns/1ps
module mtrap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0, eret_req = 1'b0;
    logic [3:0]  trap_cause = '0;
    logic [31:0] trap_pc = '0, csr_wdata = '0;
    logic [1:0]  csr_op = '0, csr_sel = '0;
    logic [31:0] csr_rdata, redirect_pc;
    logic        redirect_valid, priv_mode;

    int n_chk = 0, n_fail = 0;

    // reference model
    logic       m_mode, m_ie;
    logic [1:0] m_prev [3];
    logic [31:0] m_epc, m_scr;
    logic [3:0] m_cause;

    always #5 clk = ~clk;

    mtrap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .eret_req(eret_req), .csr_op(csr_op), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .priv_mode(priv_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return {24'b0, m_prev[2], m_prev[1], m_prev[0], m_mode, m_ie};
    endfunction

    function automatic logic [31:0] mval(input logic [1:0] s);
        case (s)
            2'd0:    return m_epc;
            2'd1:    return {28'b0, m_cause};
            2'd2:    return m_scr;
            default: return m_status();
        endcase
    endfunction

    task automatic idle();
        trap_req = 0; eret_req = 0; csr_op = 0; csr_sel = 0; csr_wdata = 0;
    endtask

    // combinational read, no clock edge consumed
    task automatic rd_chk(input logic [1:0] s, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_op = 2'd1; csr_sel = s; #1;
        chk(csr_rdata == exp, tag, csr_rdata, exp);
        idle();
    endtask

    task automatic do_cycle(input logic t, input logic [3:0] c, input logic [31:0] p,
                            input logic e, input logic [1:0] op, input logic [1:0] sel,
                            input logic [31:0] wd);
        logic [31:0] exp_rd, exp_pc;
        logic tf, rf, was_user;
        string tg, tg2;
        @(negedge clk);
        trap_req = t; trap_cause = c; trap_pc = p; eret_req = e;
        csr_op = op; csr_sel = sel; csr_wdata = wd;
        #1;
        exp_rd = (op == 2'd1 || op == 2'd3) ? mval(sel) : 32'h0;
        tg = (op == 2'd3) ? "R9 rdata" : (sel == 2'd3) ? "R4 rdata" : "R8 rdata";
        chk(csr_rdata == exp_rd, tg, csr_rdata, exp_rd);
        was_user = (m_mode == 1'b0);
        tf = t | (e & was_user);
        rf = e & ~t & ~was_user;
        exp_pc = tf ? (was_user ? 32'h100 : 32'h1C0) : m_epc;
        tg2 = (t && e) ? "R7" : (e && was_user) ? "R6" : t ? (was_user ? "R2" : "R3")
              : e ? "R5" : "R13";
        if (op == 2'd2 || op == 2'd3) begin
            if (sel == 2'd2) m_scr = wd;
            if (!tf && sel == 2'd0) m_epc = wd;
            if (!tf && sel == 2'd1) m_cause = wd[3:0];
        end
        if (tf) begin
            m_epc = p;
            m_cause = t ? c : 4'd2;
            m_prev[2] = m_prev[1]; m_prev[1] = m_prev[0]; m_prev[0] = {m_mode, m_ie};
            m_mode = 1'b1; m_ie = 1'b0;
        end else if (rf) begin
            {m_mode, m_ie} = m_prev[0];
            m_prev[0] = m_prev[1]; m_prev[1] = m_prev[2]; m_prev[2] = 2'b01;
        end
        @(posedge clk); #1;
        idle();
        chk(redirect_valid == (tf | rf), tg2, {31'b0, redirect_valid}, {31'b0, tf | rf});
        if (tf | rf) chk(redirect_pc == exp_pc, tg2, redirect_pc, exp_pc);
        chk(priv_mode == m_mode, tg2, {31'b0, priv_mode}, {31'b0, m_mode});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        m_mode = 0; m_ie = 1; m_prev[0] = 2'b01; m_prev[1] = 2'b01; m_prev[2] = 2'b01;
        m_epc = 0; m_scr = 0; m_cause = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(redirect_valid == 1'b0, "R1 redirect_valid", {31'b0, redirect_valid}, 0);
        chk(priv_mode == 1'b0, "R1 mode", {31'b0, priv_mode}, 0);
        rd_chk(2'd0, 32'h0, "R1 epc");
        rd_chk(2'd1, 32'h0, "R1 cause");
        rd_chk(2'd2, 32'h0, "R1 scratch");
        rd_chk(2'd3, 32'h55, "R1 status");
        // R2 system call from user
        do_cycle(1, 4'd8, 32'h1000, 0, 0, 0, 0);
        chk(redirect_pc == 32'h100, "R2 vector", redirect_pc, 32'h100);
        rd_chk(2'd0, 32'h1000, "R2 epc");
        rd_chk(2'd1, 32'd8, "R2 cause");
        rd_chk(2'd3, 32'h56, "R4 push");
        // R10 last mepc write wins
        do_cycle(0, 0, 0, 0, 2'd2, 2'd0, 32'h1004);
        do_cycle(0, 0, 0, 0, 2'd2, 2'd0, 32'h1008);
        do_cycle(0, 0, 0, 1, 0, 0, 0);
        chk(redirect_pc == 32'h1008, "R10 target", redirect_pc, 32'h1008);
        rd_chk(2'd3, 32'h55, "R5 pop");
        // R6 ERET from user
        do_cycle(0, 0, 32'h2000, 1, 0, 0, 0);
        rd_chk(2'd1, 32'd2, "R6 cause");
        rd_chk(2'd0, 32'h2000, "R6 epc");
        // R3 nested trap
        do_cycle(1, 4'd2, 32'h3000, 0, 0, 0, 0);
        chk(redirect_pc == 32'h1C0, "R3 vector", redirect_pc, 32'h1C0);
        rd_chk(2'd3, 32'h5A, "R4 nest");
        // R7 trap and ERET together, R12 trap beats mepc write
        do_cycle(1, 4'd8, 32'h4000, 1, 2'd2, 2'd0, 32'hDEAD);
        rd_chk(2'd1, 32'd8, "R7 cause");
        rd_chk(2'd0, 32'h4000, "R12 epc");
        // R11 status write ignored
        do_cycle(0, 0, 0, 0, 2'd2, 2'd3, 32'h0);
        rd_chk(2'd3, 32'h6A, "R11 status");
        // R9 swap
        do_cycle(0, 0, 0, 0, 2'd3, 2'd2, 32'hA5A5_0001);
        rd_chk(2'd2, 32'hA5A5_0001, "R9 scratch");
        // R5 chain of returns
        for (int i = 0; i < 4; i++) do_cycle(0, 0, 0, 1, 0, 0, 0);
        // R8 op x sel sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int op = 0; op < 4; op++)
                for (int s = 0; s < 4; s++)
                    for (int w = 0; w < 3; w++)
                        do_cycle(0, 0, 0, 0, 2'(op), 2'(s), 32'h1111_0000 * w + 32'(op * 4 + s));
            do_cycle(1, 4'd2, 32'h5000, 0, 0, 0, 0);
        end
        // pseudo-random stream against the model
        lfsr = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            do_cycle(lfsr[2:0] == 3'd0, lfsr[7:4], {lfsr[31:10], 2'b00}, lfsr[10:8] < 3'd2,
                     lfsr[12:11], lfsr[14:13], lfsr ^ 32'h0F0F_F0F0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule